// File: doc/BRIEF.md
# Mode-Selectable General-Purpose I/O Port

This block is an 8-pin general-purpose I/O port. A data register holds one bit per pin. A mode register holds a two-bit field per pin. The field chooses one of four uses: hand the pin to an external function, drive it from the data register, or sample it as an input with the pull-up enabled or disabled. A small synchronous register bus reads and writes both registers.

Writes to the data register are always stored, whatever the mode. The stored value reaches the pin only while that pin is in output mode. A read of the data register returns, for each pin, either the stored bit or the synchronized pin level, depending on that pin's mode. Two data bits are read-only and always hold zero. Each pin has an output value, an output enable and a pull-up enable toward the pad, and an input level from the pad.

Top module: `gpio_mode_port`

## Requirements
- R1: After reset the data register is all zeros and every mode field is 11. No pin has its output enable or pull-up enable asserted, pin_out is zero and bus_rdata is zero.
- R2: A write to address 0 stores bus_wdata[7:0] into the data register. Bits 5 and 4 are read-only and stay zero.
- R3: A pin whose mode is 01 has its output enable asserted, and its pin_out equals its stored data bit.
- R4: A read of address 0 returns the stored data bit for every pin whose mode is 00 or 01.
- R5: A read of address 0 returns the pin level for every pin whose mode is 10 or 11. The level passes through two synchronizing flops, so a pin change first shows in a read requested two cycles after the change.
- R6: A pin's pull-up enable is asserted exactly when its mode is 10.
- R7: A pin whose mode is 00 takes its pin_out and output enable from alt_out and alt_oe, not from the data register.
- R8: In modes 10 and 11 a pin has its output enable and pin_out at zero. Data written in the meantime is still stored and drives the pin once the mode becomes 01.
- R9: Address 1 reads and writes the mode register in full. The field of pin n sits at bits 2n+1:2n.
- R10: Addresses 2 and 3 read as zero, and writes to them change no register.
- R11: bus_rdata is loaded at the clock edge where bus_en is high and bus_we is low. It holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Level seen at each pad |
| alt_out | input | 8 | Output value from the external function, per pin |
| alt_oe | input | 8 | Output enable from the external function, per pin |
| pin_out | output | 8 | Value driven toward each pad |
| pin_oe | output | 8 | Output enable toward each pad |
| pin_pu | output | 8 | Pull-up enable toward each pad |

## Verification
The bench builds the port with its default parameters: eight pins, a two-bit address and bits 5 and 4 read-only. With these values the read-only mask lands in the middle of the word, so a single write shows a mask offset. One mixed mode word puts all four modes on neighbouring pins at once, which exposes swapped field positions in the mode decode. Back-to-back reads after a pin change show the exact depth of the synchronizer.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_ALT      = 2'b00,
    PM_OUT      = 2'b01,
    PM_IN_PU    = 2'b10,
    PM_IN_FLOAT = 2'b11
  } pin_mode_e;

  localparam int REG_DATA = 0;
  localparam int REG_MODE = 1;

  // Pin level, not stored bit, is returned on reads in either input mode.
  function automatic logic mode_reads_pin(pin_mode_e m);
    return (m == PM_IN_PU) || (m == PM_IN_FLOAT);
  endfunction

  function automatic logic mode_pullup(pin_mode_e m);
    return m == PM_IN_PU;
  endfunction

  function automatic logic mode_is_alt(pin_mode_e m);
    return m == PM_ALT;
  endfunction

  function automatic logic mode_is_out(pin_mode_e m);
    return m == PM_OUT;
  endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

  AST_SYNC_SECOND_STAGE: assert property (@(posedge clk) disable iff (rst)
    sync_out == $past(stage1_q)); // R5

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int                 NUM_PINS = 8,
  parameter int                 ADDR_W   = 2,
  parameter logic [NUM_PINS-1:0] RO_MASK = 8'h30,
  localparam int                BUS_W    = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [NUM_PINS-1:0] data_q,
  output logic [BUS_W-1:0]    mode_q,
  output logic                data_wr_hit,
  output logic                mode_wr_hit
);
  import gpio_port_pkg::*;

  localparam logic [NUM_PINS-1:0] RW_MASK = ~RO_MASK;

  assign data_wr_hit = bus_en && bus_we && (bus_addr == ADDR_W'(REG_DATA));
  assign mode_wr_hit = bus_en && bus_we && (bus_addr == ADDR_W'(REG_MODE));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (data_wr_hit) begin
      data_q <= bus_wdata[NUM_PINS-1:0] & RW_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '1;
    end else if (mode_wr_hit) begin
      mode_q <= bus_wdata;
    end
  end

  AST_MODE_RESET_FLOAT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode_q == '1)); // R1
  AST_DATA_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    data_wr_hit |=> ((data_q & RW_MASK) == ($past(bus_wdata[NUM_PINS-1:0]) & RW_MASK))); // R2
  AST_RO_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    data_wr_hit |=> ((data_q & RO_MASK) == '0)); // R2
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_wr_hit |=> $stable(data_q)); // R10
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mode_wr_hit |=> $stable(mode_q)); // R10

endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
  parameter int  NUM_PINS = 8,
  localparam int BUS_W    = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BUS_W-1:0]    mode_q,
  input  logic [NUM_PINS-1:0] data_q,
  input  logic [NUM_PINS-1:0] pin_sync,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pu,
  output logic [NUM_PINS-1:0] rd_bits
);
  import gpio_port_pkg::*;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_mode_e mode_i;
    assign mode_i = pin_mode_e'(mode_q[MODE_W*i +: MODE_W]);

    always_comb begin
      pin_out[i] = 1'b0;
      pin_oe[i]  = 1'b0;
      if (mode_is_alt(mode_i)) begin
        pin_out[i] = alt_out[i];
        pin_oe[i]  = alt_oe[i];
      end else if (mode_is_out(mode_i)) begin
        pin_out[i] = data_q[i];
        pin_oe[i]  = 1'b1;
      end
    end

    assign pin_pu[i]  = mode_pullup(mode_i);
    assign rd_bits[i] = mode_reads_pin(mode_i) ? pin_sync[i] : data_q[i];

    AST_INPUT_NEVER_DRIVES: assert property (@(posedge clk) disable iff (rst)
      mode_q[MODE_W*i+1] |-> (!pin_oe[i] && !pin_out[i])); // R8
    AST_OUTPUT_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (rst)
      (mode_q[MODE_W*i +: MODE_W] == 2'b01) |-> (pin_oe[i] && (pin_out[i] == data_q[i]))); // R3
    AST_ALT_PASSTHROUGH: assert property (@(posedge clk) disable iff (rst)
      (mode_q[MODE_W*i +: MODE_W] == 2'b00) |-> ((pin_oe[i] == alt_oe[i]) && (pin_out[i] == alt_out[i]))); // R7
  end

  AST_PULLUP_NOT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0); // R6

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port #(
  parameter int                 NUM_PINS = 8,
  parameter int                 ADDR_W   = 2,
  parameter logic [NUM_PINS-1:0] RO_MASK = 8'h30,
  localparam int                BUS_W    = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] alt_out,
  input  logic [NUM_PINS-1:0] alt_oe,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_pu
);
  import gpio_port_pkg::*;

  logic [NUM_PINS-1:0] data_q;
  logic [BUS_W-1:0]    mode_q;
  logic                data_wr_hit;
  logic                mode_wr_hit;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] rd_bits;
  logic                rd_hit;
  logic [BUS_W-1:0]    rd_next;

  gpio_port_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .RO_MASK  (RO_MASK)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .data_q      (data_q),
    .mode_q      (mode_q),
    .data_wr_hit (data_wr_hit),
    .mode_wr_hit (mode_wr_hit)
  );

  gpio_port_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_port_pinmux #(.NUM_PINS(NUM_PINS)) u_pinmux (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .data_q   (data_q),
    .pin_sync (pin_sync),
    .alt_out  (alt_out),
    .alt_oe   (alt_oe),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .pin_pu   (pin_pu),
    .rd_bits  (rd_bits)
  );

  assign rd_hit = bus_en && !bus_we;

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(REG_DATA)) begin
      rd_next[NUM_PINS-1:0] = rd_bits;
    end else if (bus_addr == ADDR_W'(REG_MODE)) begin
      rd_next = mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_hit) begin
      bus_rdata <= rd_next;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(bus_rdata)); // R11
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ((pin_oe == '0) && (pin_pu == '0) && (bus_rdata == '0))); // R1

endmodule

// File: tb/gpio_mode_port_bench.sv
module gpio_mode_port_bench;

  localparam int NP = 8;
  localparam int BW = 16;

  typedef struct packed {
    logic [BW-1:0] mode;
    logic [NP-1:0] wdata;
    logic [NP-1:0] pins;
    logic [NP-1:0] aout;
    logic [NP-1:0] aoe;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'h5555, 8'hFF, 8'h00, 8'h00, 8'h00},
    '{16'hAAAA, 8'h00, 8'hA5, 8'hFF, 8'hFF},
    '{16'h0000, 8'h3C, 8'hFF, 8'h5A, 8'hF0},
    '{16'h1B6C, 8'hC3, 8'h96, 8'h0F, 8'h33},
    '{16'hFFFF, 8'h7E, 8'h0F, 8'hAA, 8'h55}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] alt_out = '0;
  logic [NP-1:0] alt_oe = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic [NP-1:0] pin_pu;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mode_port u_gpio_mode_port (
    .clk (clk), .rst (rst), .bus_en (bus_en), .bus_we (bus_we),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .pin_in (pin_in), .alt_out (alt_out), .alt_oe (alt_oe),
    .pin_out (pin_out), .pin_oe (pin_oe), .pin_pu (pin_pu)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [BW-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [BW-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  // Bench model: walks the pins and applies the mode rules from the requirements.
  function automatic logic [4*NP-1:0] model(vec_t v);
    logic [NP-1:0] rd, oe, out, pu;
    for (int p = 0; p < NP; p++) begin
      logic [1:0] m;
      logic       st;
      m  = v.mode[2*p +: 2];
      st = (p == 4 || p == 5) ? 1'b0 : v.wdata[p];
      case (m)
        2'b00: begin rd[p] = st;        oe[p] = v.aoe[p]; out[p] = v.aout[p]; pu[p] = 1'b0; end
        2'b01: begin rd[p] = st;        oe[p] = 1'b1;     out[p] = st;        pu[p] = 1'b0; end
        2'b10: begin rd[p] = v.pins[p]; oe[p] = 1'b0;     out[p] = 1'b0;      pu[p] = 1'b1; end
        default: begin rd[p] = v.pins[p]; oe[p] = 1'b0;   out[p] = 1'b0;      pu[p] = 1'b0; end
      endcase
    end
    return {rd, oe, out, pu};
  endfunction

  initial begin
    logic [BW-1:0] r;
    logic [4*NP-1:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet reset state
    check("R1", "pin_oe after reset", 32'(pin_oe), 32'h0);
    check("R1", "pin_pu after reset", 32'(pin_pu), 32'h0);
    check("R1", "pin_out after reset", 32'(pin_out), 32'h0);
    check("R1", "bus_rdata after reset", 32'(bus_rdata), 32'h0);
    bus_read(2'd1, r);
    check("R1", "mode reset value", 32'(r), 32'hFFFF);
    bus_write(2'd1, 16'h5555);
    bus_read(2'd0, r);
    check("R1", "data reset value", 32'(r), 32'h0);

    // Vector table: R2 R3 R4 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      bus_write(2'd1, VECS[k].mode);
      bus_write(2'd0, {8'h00, VECS[k].wdata});
      @(negedge clk);
      pin_in = VECS[k].pins; alt_out = VECS[k].aout; alt_oe = VECS[k].aoe;
      repeat (3) @(negedge clk);
      e = model(VECS[k]);
      bus_read(2'd0, r);
      check("R2/R4/R5", "data read", 32'(r), 32'(e[4*NP-1 -: NP]));
      check("R3/R7", "pin_oe", 32'(pin_oe), 32'(e[3*NP-1 -: NP]));
      check("R3/R7/R8", "pin_out", 32'(pin_out), 32'(e[2*NP-1 -: NP]));
      check("R6", "pin_pu", 32'(pin_pu), 32'(e[NP-1:0]));
      bus_read(2'd1, r);
      check("R9", "mode readback", 32'(r), 32'(VECS[k].mode));
    end

    // R5: two-flop latency, reads back to back after a pin change (all modes 11 now)
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 2'd0; pin_in = 8'h81;
    @(negedge clk);
    check("R5", "read one edge after change", 32'(bus_rdata), 32'h00);
    @(negedge clk);
    check("R5", "read two edges after change", 32'(bus_rdata), 32'h00);
    @(negedge clk);
    check("R5", "read three edges after change", 32'(bus_rdata), 32'h81);
    bus_en = 1'b0;

    // R11: no read request, rdata holds while pins move
    pin_in = 8'h18;
    repeat (4) @(negedge clk);
    check("R11", "rdata held without read", 32'(bus_rdata), 32'h81);

    // R8: write in input mode is stored but does not drive
    bus_write(2'd0, 16'h00FF);
    check("R8", "pin_oe in input mode", 32'(pin_oe), 32'h0);
    check("R8", "pin_out in input mode", 32'(pin_out), 32'h0);
    bus_write(2'd1, 16'h5555);
    check("R8", "stored data drives after switch", 32'(pin_out), 32'hCF);
    check("R3", "all outputs enabled", 32'(pin_oe), 32'hFF);

    // R10: unmapped addresses
    bus_write(2'd2, 16'h0000);
    bus_write(2'd3, 16'h0000);
    bus_read(2'd2, r);
    check("R10", "addr 2 reads zero", 32'(r), 32'h0);
    bus_read(2'd3, r);
    check("R10", "addr 3 reads zero", 32'(r), 32'h0);
    bus_read(2'd1, r);
    check("R10", "mode unchanged", 32'(r), 32'h5555);
    bus_read(2'd0, r);
    check("R10", "data unchanged", 32'(r), 32'hCF);

    // R2: read-only bits in output mode
    bus_write(2'd0, 16'hFF30);
    bus_read(2'd0, r);
    check("R2", "read-only bits stay zero", 32'(r), 32'h00);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule